// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with two countdown stages. Once enabled, a prescaled tick decrements the first stage from its preload value. When the first stage expires, the block can raise an interrupt and then loads the second stage from a separate preload. When the second stage expires in watchdog function, the block drives a fixed-length reset pulse and sets a sticky timed-out flag. Counting then starts again from stage one.

Software keeps the system alive by writing a restart request to the reload register. That register, and the two preload registers, accept one write only after a two-value key has been written to the reload register. A control register holds the enable, the function select and a lock bit. Once the lock is set, software cannot switch the watchdog off or change the preloads until reset. A configuration register selects the tick rate, the interrupt behaviour and whether the reset output is used. Software converts a timeout in seconds to a preload by shifting it left by 9. The supported range is 1 to 2046 seconds, and the default is 30 seconds.

Register offsets: stage-1 preload 0x00, stage-2 preload 0x04, interrupt status 0x08, reload 0x0C, configuration 0x10, control 0x14. Reads are combinational on the address.

Top module: `tsw_watchdog`

## Requirements
- R1: After reset, both preloads read 0x3C00, configuration reads 0x03, control reads 0, interrupt status and reload read 0, and both outputs are low.
- R2: Writing 0x80 and then 0x86 to the reload register (offset 0x0C) opens exactly one protected write: to preload 0x00, to preload 0x04 or to reload. A second protected write without a new key is ignored.
- R3: A reload-register write that does not match the expected key value returns the key sequence to its start. A preload write made without a completed key has no effect.
- R4: The tick is the clock divided by 2^SLOW_LOG2 when configuration bit 2 is 0, and by 2^FAST_LOG2 when it is 1. With tick period D, stage one expires P1·D cycles after the enabling write.
- R5: Stage-one expiry sets interrupt-status bit 0, which drives irq_o, unless configuration bits 1:0 equal 3. Writing 1 to status bit 0 clears it.
- R6: In watchdog function (control bit 2 = 0), stage two expires P2·D cycles after stage one. This sets reload bit 9. If configuration bit 5 is 0, it also drives wdt_rst_o high for exactly RST_HOLD cycles.
- R7: In timer function (control bit 2 = 1), stage-two expiry neither pulses wdt_rst_o nor sets the flag, and stage one restarts.
- R8: A keyed reload write with bit 8 set restarts stage one from its preload with a fresh prescaler. It wins over an expiry in the same cycle.
- R9: Reload bit 9 is cleared only by a keyed reload write with bit 9 set.
- R10: Clearing control bit 1 stops both stages. After re-enabling, stage one runs its full P1·D cycles.
- R11: Control bit 0 stays set until reset. While it is set, a control write cannot clear any bit and preload writes are ignored.
- R12: A preload of zero expires after one tick.
- R13: A write with bus_wide low updates only bits 15:0 of a preload and keeps its upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Stage-one interrupt (status bit 0) |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A keepalive reload and a stage-one expiry can land on the same clock edge. The bench provokes this by counting cycles from the enabling write and placing the two key writes so that the reload write's edge is exactly P1·D cycles later. It is judged through the event scoreboard: no interrupt may appear on that edge, and the interrupt must arrive exactly P1·D cycles after the reload.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;

  typedef enum logic {
    STG_ONE = 1'b0,
    STG_TWO = 1'b1
  } stage_e;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_PRE1 = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_PRE2 = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ISR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_RLD  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h14;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  localparam int unsigned RLD_KICK_BIT = 8;
  localparam int unsigned RLD_FLAG_BIT = 9;

  localparam int unsigned CTL_LOCK_BIT  = 0;
  localparam int unsigned CTL_EN_BIT    = 1;
  localparam int unsigned CTL_TIMER_BIT = 2;

  localparam int unsigned CFG_FAST_BIT    = 2;
  localparam int unsigned CFG_NORST_BIT   = 5;
  localparam logic [1:0]  CFG_IRQ_NONE    = 2'b11;
  localparam logic [5:0]  CFG_RESET_VALUE = 6'h03;

  // Seconds-to-preload conversion used for the reset value.
  function automatic logic [31:0] secs_to_preload(input int unsigned secs,
                                                  input int unsigned shift);
    return 32'(secs) << shift;
  endfunction

  // A narrow access replaces only the low half of the current value.
  function automatic logic [31:0] merge_access(input logic [31:0] cur,
                                               input logic [31:0] wdata,
                                               input logic        wide);
    return wide ? wdata : {cur[31:16], wdata[15:0]};
  endfunction

endpackage

// File: rtl/tsw_keyseq.sv
module tsw_keyseq
  import tsw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rld_wr,
  input  logic        prot_wr,
  input  logic [15:0] wdata16,
  output logic        open_o,
  output logic        take_o
);

  key_state_e state_q, state_d;

  assign open_o = (state_q == KEY_OPEN);
  assign take_o = open_o && prot_wr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KEY_IDLE: if (rld_wr) state_d = (wdata16 == KEY_FIRST)  ? KEY_HALF : KEY_IDLE;
      KEY_HALF: if (rld_wr) state_d = (wdata16 == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
      KEY_OPEN: if (prot_wr) state_d = KEY_IDLE;
      default:  state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  // The open state is reached only through the half-key state.
  assert_open_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_OPEN) |-> ($past(state_q) == KEY_HALF || $past(state_q) == KEY_OPEN));

  // One protected write uses up the key.
  assert_single_use_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (state_q != KEY_OPEN));

endmodule

// File: rtl/tsw_prescale.sv
module tsw_prescale #(
  parameter int unsigned SLOW_LOG2 = 15,
  parameter int unsigned FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic tick
);

  logic [SLOW_LOG2-1:0] pcnt_q;
  logic                 slow_wrap;
  logic                 fast_wrap;

  assign slow_wrap = &pcnt_q;
  assign fast_wrap = &pcnt_q[FAST_LOG2-1:0];
  assign tick      = run && !restart && (fast ? fast_wrap : slow_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt_q <= '0;
    else if (!run || restart) pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + 1'b1;
  end

  // Ticks never come on back-to-back cycles.
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/tsw_countdown.sv
module tsw_countdown
  import tsw_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output stage_e           stage_o,
  output logic             s1_done,
  output logic             s2_done
);

  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;
  logic             step;

  // Zero and one both end the stage on the next tick.
  assign at_end  = (cnt_q <= CNT_W'(1));
  assign step    = run && !kick && tick;
  assign s1_done = step && at_end && (stage_q == STG_ONE);
  assign s2_done = step && at_end && (stage_q == STG_TWO);
  assign stage_o = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_ONE;
      cnt_q   <= '0;
    end else if (!run || kick) begin
      stage_q <= STG_ONE;
      cnt_q   <= pre1;
    end else if (tick) begin
      if (at_end) begin
        if (stage_q == STG_ONE) begin
          stage_q <= STG_TWO;
          cnt_q   <= pre2;
        end else begin
          stage_q <= STG_ONE;
          cnt_q   <= pre1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // A keepalive always lands in stage one.
  assert_kick_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick) |=> (stage_q == STG_ONE));

  // Stage two is entered only from a stage-one expiry.
  assert_stage2_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_q == STG_TWO) |-> $past(s1_done));

endmodule

// File: rtl/tsw_watchdog.sv
module tsw_watchdog
  import tsw_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned SLOW_LOG2 = 15,
  parameter int unsigned FAST_LOG2 = 5,
  parameter int unsigned RST_HOLD  = 8,
  parameter int unsigned DEF_SECS  = 30,
  parameter int unsigned SEC_SHIFT = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wdt_rst_o
);

  localparam int unsigned      HOLD_W    = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] PRE_RESET = CNT_W'(secs_to_preload(DEF_SECS, SEC_SHIFT));

  // Decoded bus events.
  logic wr_any, wr_pre1, wr_pre2, wr_isr, wr_rld, wr_cfg, wr_ctl;
  logic prot_wr, key_open, take;
  logic kick, flag_clr;

  // Register state.
  logic [CNT_W-1:0]  pre1_q, pre2_q;
  logic [5:0]        cfg_q;
  logic [2:0]        ctl_q;
  logic              irq_q, flag_q;
  logic [HOLD_W-1:0] hold_q;

  // Internal events for the checks.
  logic   lock_q, en, timer_fn, fast;
  logic   tick, s1_done, s2_done;
  logic   irq_req, rst_req;
  stage_e stage;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_pre1 = wr_any && (bus_addr == OFF_PRE1);
  assign wr_pre2 = wr_any && (bus_addr == OFF_PRE2);
  assign wr_isr  = wr_any && (bus_addr == OFF_ISR);
  assign wr_rld  = wr_any && (bus_addr == OFF_RLD);
  assign wr_cfg  = wr_any && (bus_addr == OFF_CFG);
  assign wr_ctl  = wr_any && (bus_addr == OFF_CTL);
  assign prot_wr = wr_pre1 || wr_pre2 || wr_rld;

  assign lock_q   = ctl_q[CTL_LOCK_BIT];
  assign en       = ctl_q[CTL_EN_BIT];
  assign timer_fn = ctl_q[CTL_TIMER_BIT];
  assign fast     = cfg_q[CFG_FAST_BIT];

  assign kick     = take && wr_rld && bus_wdata[RLD_KICK_BIT];
  assign flag_clr = take && wr_rld && bus_wdata[RLD_FLAG_BIT];
  assign irq_req  = s1_done && (cfg_q[1:0] != CFG_IRQ_NONE);
  assign rst_req  = s2_done && !timer_fn && !cfg_q[CFG_NORST_BIT];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  tsw_keyseq u_keyseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rld_wr  (wr_rld),
    .prot_wr (prot_wr),
    .wdata16 (bus_wdata[15:0]),
    .open_o  (key_open),
    .take_o  (take)
  );

  tsw_prescale #(
    .SLOW_LOG2 (SLOW_LOG2),
    .FAST_LOG2 (FAST_LOG2)
  ) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (kick),
    .fast    (fast),
    .tick    (tick)
  );

  tsw_countdown #(
    .CNT_W (CNT_W)
  ) u_countdown (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .tick    (tick),
    .kick    (kick),
    .pre1    (pre1_q),
    .pre2    (pre2_q),
    .stage_o (stage),
    .s1_done (s1_done),
    .s2_done (s2_done)
  );

  // Preloads: keyed and unlocked only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= PRE_RESET;
      pre2_q <= PRE_RESET;
    end else if (take && !lock_q) begin
      if (wr_pre1) pre1_q <= CNT_W'(merge_access(32'(pre1_q), bus_wdata, bus_wide));
      if (wr_pre2) pre2_q <= CNT_W'(merge_access(32'(pre2_q), bus_wdata, bus_wide));
    end
  end

  // Configuration and control. Once locked, control bits can only be set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET_VALUE;
      ctl_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata[5:0];
      if (wr_ctl) ctl_q <= lock_q ? (ctl_q | bus_wdata[2:0]) : bus_wdata[2:0];
    end
  end

  // Interrupt status and timed-out flag; a set wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (irq_req)                      irq_q <= 1'b1;
      else if (wr_isr && bus_wdata[0])  irq_q <= 1'b0;
      if (s2_done && !timer_fn)         flag_q <= 1'b1;
      else if (flag_clr)                flag_q <= 1'b0;
    end
  end

  // Reset pulse stretcher.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (rst_req)        hold_q <= HOLD_W'(RST_HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign irq_o     = irq_q;
  assign wdt_rst_o = (hold_q != '0);

  always_comb begin
    unique case (bus_addr)
      OFF_PRE1: bus_rdata = 32'(pre1_q);
      OFF_PRE2: bus_rdata = 32'(pre2_q);
      OFF_ISR:  bus_rdata = {31'd0, irq_q};
      OFF_RLD:  bus_rdata = 32'(flag_q) << RLD_FLAG_BIT;
      OFF_CFG:  bus_rdata = {26'd0, cfg_q};
      OFF_CTL:  bus_rdata = {29'd0, ctl_q};
      default:  bus_rdata = '0;
    endcase
  end

  // A preload changes only after a keyed, unlocked cycle.
  assert_pre_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre1_q != $past(pre1_q) || pre2_q != $past(pre2_q)) |-> $past(key_open && !lock_q));

  // The lock bit is sticky.
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);

  // A locked, running watchdog stays enabled.
  assert_en_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q && en) |-> en);

  // The interrupt rises only on a stage-one expiry.
  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(s1_done) && $past(stage) == STG_ONE));

  // A reset pulse always comes with the timed-out flag.
  assert_rst_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> flag_q);

  // Timer function never starts a reset pulse.
  assert_timer_norst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(!timer_fn));

endmodule

// File: tb/tsw_watchdog_tb_top.sv
module tsw_watchdog_tb_top;

  localparam int SLOW = 4;
  localparam int FAST = 2;
  localparam int HOLD = 5;
  localparam int DS   = 1 << SLOW;
  localparam int DF   = 1 << FAST;

  localparam logic [4:0] A_P1 = 5'h00, A_P2 = 5'h04, A_ISR = 5'h08,
                         A_RLD = 5'h0C, A_CFG = 5'h10, A_CTL = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdt_rst_o;

  always #5 clk = ~clk;

  tsw_watchdog #(
    .SLOW_LOG2 (SLOW),
    .FAST_LOG2 (FAST),
    .RST_HOLD  (HOLD)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int exp_kind[$];
  int exp_cyc[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: 1 = interrupt rise, 2 = reset pulse rise.
  task automatic expect_evt(input int kind, input int at);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
  endtask

  // Called at a negedge; the write takes the next posedge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic wide = 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(A_RLD, 32'h80);
    wr(A_RLD, 32'h86);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor side of the scoreboard.
  logic irq_d = 1'b0, rst_d = 1'b0;
  int   width = 0;

  task automatic note(input int kind);
    n_chk++;
    if (exp_kind.size() == 0) begin
      n_bad++;
      $display("FAIL %s unexpected event actual=%0d@%0d expected=none",
               (kind == 1) ? "R5" : "R6", kind, cyc);
    end else begin
      int k;
      int c;
      k = exp_kind.pop_front();
      c = exp_cyc.pop_front();
      if (k != kind || c != cyc) begin
        n_bad++;
        $display("FAIL R4 event actual=%0d@%0d expected=%0d@%0d", kind, cyc, k, c);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o && !irq_d) note(1);
      if (wdt_rst_o && !rst_d) note(2);
      if (wdt_rst_o) width++;
      else if (rst_d) begin
        check("R6 pulse width", 32'(width), 32'(HOLD));
        width = 0;
      end
      irq_d = irq_o;
      rst_d = wdt_rst_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0;
    int c1;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state.
    rd(A_P1, v);  check("R1 pre1", v, 32'h3C00);
    rd(A_P2, v);  check("R1 pre2", v, 32'h3C00);
    rd(A_CFG, v); check("R1 cfg", v, 32'h03);
    rd(A_CTL, v); check("R1 ctl", v, 32'h0);
    rd(A_ISR, v); check("R1 isr", v, 32'h0);
    rd(A_RLD, v); check("R1 rld", v, 32'h0);
    check("R1 outputs", {30'd0, irq_o, wdt_rst_o}, 32'h0);
    @(negedge clk);

    // R3: no key, then a broken key.
    wr(A_P1, 32'h5);
    rd(A_P1, v); check("R3 no key", v, 32'h3C00);
    @(negedge clk);
    wr(A_RLD, 32'h80); wr(A_RLD, 32'h55); wr(A_RLD, 32'h86); wr(A_P1, 32'h5);
    rd(A_P1, v); check("R3 broken key", v, 32'h3C00);
    @(negedge clk);

    // R2: one write per key.
    unlock(); wr(A_P1, 32'h000F_0003);
    rd(A_P1, v); check("R2 keyed write", v, 32'hF_0003);
    @(negedge clk);
    wr(A_P1, 32'h7);
    rd(A_P1, v); check("R2 key used up", v, 32'hF_0003);
    @(negedge clk);

    // R13: narrow write keeps upper bits.
    unlock(); wr(A_P1, 32'hAAAA_0004, 1'b0);
    rd(A_P1, v); check("R13 narrow", v, 32'hF_0004);
    @(negedge clk);
    unlock(); wr(A_P1, 32'h3);
    unlock(); wr(A_P2, 32'h2);
    rd(A_P2, v); check("R2 pre2", v, 32'h2);
    @(negedge clk);

    // R4/R5/R6: full watchdog sequence, slow tick.
    wr(A_CFG, 32'h0);
    wr(A_CTL, 32'h2); c0 = cyc;
    expect_evt(1, c0 + 3*DS);
    expect_evt(2, c0 + 5*DS);
    wait_until(c0 + 5*DS + HOLD + 2);
    rd(A_ISR, v); check("R5 status set", v, 32'h1);
    rd(A_RLD, v); check("R6 flag set", v, 32'h200);
    @(negedge clk);
    wr(A_CTL, 32'h0);
    wr(A_ISR, 32'h1);
    check("R5 w1c", {31'd0, irq_o}, 32'h0);
    wr(A_RLD, 32'h200);
    rd(A_RLD, v); check("R9 unkeyed clear", v, 32'h200);
    @(negedge clk);
    unlock(); wr(A_RLD, 32'h200);
    rd(A_RLD, v); check("R9 keyed clear", v, 32'h0);
    @(negedge clk);
    repeat (150) @(negedge clk);   // R10: disabled, no events expected

    // R4: fast tick.
    wr(A_CFG, 32'h4);
    wr(A_CTL, 32'h2); c0 = cyc;
    expect_evt(1, c0 + 3*DF);
    wait_until(c0 + 3*DF + 2);
    wr(A_CTL, 32'h0); wr(A_ISR, 32'h1);

    // R8: keepalive on the same edge as the stage-one expiry.
    wr(A_CFG, 32'h0);
    wr(A_CTL, 32'h2); c0 = cyc;
    t = c0 + 3*DS;
    wait_until(t - 3);
    unlock(); wr(A_RLD, 32'h100);
    expect_evt(1, t + 3*DS);
    wait_until(t + 3*DS + 2);
    wr(A_CTL, 32'h0); wr(A_ISR, 32'h1);

    // R5/R6: no interrupt type and masked reset still flag.
    wr(A_CFG, 32'h23);
    wr(A_CTL, 32'h2); c0 = cyc;
    wait_until(c0 + 5*DS + 4);
    check("R5 no irq type", {31'd0, irq_o}, 32'h0);
    rd(A_RLD, v); check("R6 masked flag", v, 32'h200);
    @(negedge clk);
    wr(A_CTL, 32'h0);
    unlock(); wr(A_RLD, 32'h200);

    // R7: timer function.
    wr(A_CFG, 32'h0);
    wr(A_CTL, 32'h6); c0 = cyc;
    expect_evt(1, c0 + 3*DS);
    wait_until(c0 + 3*DS + 8);
    wr(A_ISR, 32'h1);
    expect_evt(1, c0 + 8*DS);
    wait_until(c0 + 8*DS + 2);
    rd(A_RLD, v); check("R7 no flag", v, 32'h0);
    @(negedge clk);
    wr(A_CTL, 32'h0); wr(A_ISR, 32'h1);

    // R10: halt mid-count, restart gets a full count.
    wr(A_CTL, 32'h2); c0 = cyc;
    wait_until(c0 + 30);
    wr(A_CTL, 32'h0);
    repeat (20) @(negedge clk);
    wr(A_CTL, 32'h2); c1 = cyc;
    expect_evt(1, c1 + 3*DS);
    wait_until(c1 + 3*DS + 2);
    wr(A_CTL, 32'h0); wr(A_ISR, 32'h1);

    // R12: zero preloads.
    unlock(); wr(A_P1, 32'h0);
    unlock(); wr(A_P2, 32'h0);
    rd(A_P1, v); check("R12 pre1 zero", v, 32'h0);
    @(negedge clk);
    wr(A_CTL, 32'h2); c0 = cyc;
    expect_evt(1, c0 + DS);
    expect_evt(2, c0 + 2*DS);
    wait_until(c0 + 2*DS + HOLD + 2);
    wr(A_CTL, 32'h0); wr(A_ISR, 32'h1);
    unlock(); wr(A_RLD, 32'h200);

    // R11: lock.
    unlock(); wr(A_P1, 32'h3);
    unlock(); wr(A_P2, 32'h2);
    wr(A_CTL, 32'h3); c0 = cyc;
    expect_evt(1, c0 + 3*DS);
    expect_evt(2, c0 + 5*DS);
    wr(A_CTL, 32'h0);
    rd(A_CTL, v); check("R11 ctl kept", v, 32'h3);
    @(negedge clk);
    unlock(); wr(A_P1, 32'h9);
    rd(A_P1, v); check("R11 pre1 kept", v, 32'h3);
    @(negedge clk);
    wait_until(c0 + 5*DS + HOLD + 3);

    check("R6 all events seen", 32'(exp_kind.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule